// File: doc/BRIEF.md
# I2C Master Packed-Buffer Transmit Engine

This block is the write side of a register-controlled I2C master. Software loads a small transmit buffer, organised as 32-bit words, through a word-addressed register port. It then drives the bus through a control register. A START request produces a START condition and parks the bus with SCL held low. A write to the count register then sends that many buffer bytes, MSB first. After each byte the engine releases SDA for the acknowledge bit and samples it. A STOP request in the parked state closes the transfer.

Each bus event latches a flag in a pending register. Software clears these flags by writing 1 to them. A separate enable register masks which flags reach the single interrupt output. The engine has no repeated-START state. Software gets the same effect by writing zero to the control register, which parks the engine without a STOP, and then issuing a fresh START. Bus timing comes from an external bit-tick pulse; each bus bit takes four ticks. SCL and SDA are open-drain: each has a drive-low output and a sampled input.

Top module: `i2c_tx_engine`

## Requirements
- R1: After reset, both drive-low outputs are 0, the interrupt is 0, and reads of control (word 0), interrupt enable (word 1), pending (word 2) and count (word 3) return 0. Read data appears on the clock edge after the address is presented.
- R2: Writing control with bit 0 (enable) set, bits [2:1] (mode) zero and bit 3 (START request) set produces a START condition: SDA falls while SCL is high. Then SCL is held low, pending bit 4 is set, and control bit 3 clears itself.
- R3: A count write of 1 to BYTES (BYTES = 4 x BUF_WORDS) while enabled sends that many buffer bytes. Sending starts at byte 0 of word 0 and moves upward; byte k of a word is bits [8k+7:8k], sent MSB first. Buffer word w is at register word BUF_WORDS+w.
- R4: Every byte sent sets pending bit 0. Sending the full count sets pending bit 2.
- R5: A NACK (SDA high in the acknowledge bit) sets pending bit 6. When control bit 6 is 0, the remaining bytes of the chunk are still sent.
- R6: When control bit 6 is 1, a NACKed byte ends the chunk. No further byte is sent, pending bit 2 stays clear, and SCL stays held low.
- R7: Setting control bit 4 (STOP request) in the parked state produces a STOP condition: SDA rises while SCL is high. Then both lines are released, pending bit 5 is set, and control bit 4 clears itself.
- R8: Another valid count write after a chunk finishes sends a further chunk from byte 0, with no new START.
- R9: Writing zero to control parks the engine with no STOP condition and no pending bit 5. A later START request produces a new START condition.
- R10: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. Pending bits 1 and 3 are never set.
- R11: The interrupt output is the registered OR of (pending AND enable), one cycle behind them.
- R12: Count writes of 0 or above BYTES are ignored; the stored count and the bus are unchanged. A START request with a non-zero mode is ignored.
- R13: Within a byte, SDA changes only while SCL is low. No START or STOP condition appears inside a chunk. The acknowledge is sampled in the ninth SCL high phase, once SCL reads high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | Quarter-bit timing pulse from the SCL timing generator |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | WAW+1 | Word address: control words 0 to 3, buffer at BUF_WORDS and above |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the control words |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the engine with BUF_WORDS = 4, which gives a 16-byte buffer. A full-buffer chunk, the first rejected count (17) and byte order across every word lane can then be checked in a few thousand cycles. A behavioural slave on the open-drain wires records each byte and counts START and STOP conditions. It can NACK a chosen byte, so the continue and halt NACK paths and the park-then-restart path are all observed on the bus.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int CB_EN    = 0;
  localparam int CB_START = 3;
  localparam int CB_STOP  = 4;
  localparam int CB_HALT  = 6;

  localparam int PB_BYTE   = 0;
  localparam int PB_RXBYTE = 1;
  localparam int PB_TXDONE = 2;
  localparam int PB_RXDONE = 3;
  localparam int PB_START  = 4;
  localparam int PB_STOP   = 5;
  localparam int PB_NACK   = 6;
  localparam int NPEND     = 7;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_IEN  = 2'd1;
  localparam logic [1:0] RA_PEND = 2'd2;
  localparam logic [1:0] RA_CNT  = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_STA, S_HOLD, S_LDA, S_LDB, S_SEND, S_STP, S_PARK
  } bus_st_t;

  typedef struct packed {
    logic nack;
    logic stopped;
    logic started;
    logic tx_done;
    logic byte_sent;
  } bus_evt_t;
endpackage

// File: rtl/i2ct_txbuf.sv
module i2ct_txbuf #(
  parameter int WORDS = 8,
  localparam int AW = $clog2(WORDS),
  localparam int IW = AW + 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [IW-1:0] idx,
  output logic [7:0]    rbyte
);
  logic [31:0] mem [WORDS];
  logic [31:0] rword;
  logic [1:0]  lane_q;

  // Write port and registered read port, in a shape block RAM can take.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rword  <= mem[idx[IW-1:2]];
    lane_q <= idx[1:0];
  end

  always_comb rbyte = 8'(rword >> {lane_q, 3'b000});
endmodule

// File: rtl/i2ct_regs.sv
module i2ct_regs
  import i2ct_pkg::*;
#(
  parameter int BYTES = 32,
  localparam int CNT_W = $clog2(BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             sel_ctl,
  input  logic [1:0]       ra,
  input  logic [31:0]      wdata,
  input  bus_evt_t         evt,
  input  logic             go_take,
  output logic             en,
  output logic [1:0]       mode,
  output logic             start_req,
  output logic             stop_req,
  output logic             halt,
  output logic             go,
  output logic [CNT_W-1:0] cnt,
  output logic             irq,
  output logic [31:0]      rdata
);
  logic [NPEND-1:0] ctrl_q, ien_q, pend_q, set_v, clr_v;
  logic [CNT_W-1:0] cnt_q;
  logic go_q, irq_q;
  logic wr_ctrl, wr_ien, wr_pend, wr_cnt, cnt_ok;

  assign wr_ctrl = we && sel_ctl && ra == RA_CTRL;
  assign wr_ien  = we && sel_ctl && ra == RA_IEN;
  assign wr_pend = we && sel_ctl && ra == RA_PEND;
  assign wr_cnt  = we && sel_ctl && ra == RA_CNT;
  assign cnt_ok  = (wdata != 32'd0) && (wdata <= 32'(BYTES));

  always_comb begin
    set_v = '0;
    set_v[PB_BYTE]   = evt.byte_sent;
    set_v[PB_TXDONE] = evt.tx_done;
    set_v[PB_START]  = evt.started;
    set_v[PB_STOP]   = evt.stopped;
    set_v[PB_NACK]   = evt.nack;
    clr_v = wr_pend ? wdata[NPEND-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      pend_q <= '0;
      cnt_q  <= '0;
      go_q   <= 1'b0;
      irq_q  <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata[NPEND-1:0] & 7'h5F;
      else begin
        if (evt.started) ctrl_q[CB_START] <= 1'b0;
        if (evt.stopped) ctrl_q[CB_STOP]  <= 1'b0;
      end
      if (wr_ien) ien_q <= wdata[NPEND-1:0];
      pend_q <= (pend_q & ~clr_v) | set_v;
      if (wr_cnt && cnt_ok && ctrl_q[CB_EN]) begin
        cnt_q <= wdata[CNT_W-1:0];
        go_q  <= 1'b1;
      end else if (go_take || !ctrl_q[CB_EN]) begin
        go_q <= 1'b0;
      end
      irq_q <= |(pend_q & ien_q);
      if (!sel_ctl) rdata <= '0;
      else begin
        case (ra)
          RA_CTRL: rdata <= 32'(ctrl_q);
          RA_IEN:  rdata <= 32'(ien_q);
          RA_PEND: rdata <= 32'(pend_q);
          default: rdata <= 32'(cnt_q);
        endcase
      end
    end
  end

  assign en        = ctrl_q[CB_EN];
  assign mode      = ctrl_q[2:1];
  assign start_req = ctrl_q[CB_START];
  assign stop_req  = ctrl_q[CB_STOP];
  assign halt      = ctrl_q[CB_HALT];
  assign go        = go_q;
  assign cnt       = cnt_q;
  assign irq       = irq_q;

  // R10: a write-1 clears the named bits when no event sets them that cycle
  p_pend_w1c_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_pend && set_v == '0) |=> ((pend_q & $past(wdata[NPEND-1:0])) == '0));

  // R10: receive-side flags never rise in this engine
  p_rx_flags_r10: assert property (@(posedge clk) disable iff (rst)
    (pend_q[PB_RXBYTE] == 1'b0 && pend_q[PB_RXDONE] == 1'b0));

  // R11: masked-off pending flags cannot raise the interrupt
  p_irq_mask_r11: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & ien_q) == '0) |=> !irq_q);
endmodule

// File: rtl/i2ct_bus.sv
module i2ct_bus
  import i2ct_pkg::*;
#(
  parameter int BYTES = 32,
  localparam int CNT_W = $clog2(BYTES + 1),
  localparam int IW = $clog2(BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic [1:0]       mode,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             halt,
  input  logic             go,
  input  logic [CNT_W-1:0] cnt,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [7:0]       rbyte,
  output logic [IW-1:0]    idx,
  output logic             scl_low,
  output logic             sda_low,
  output logic             go_take,
  output bus_evt_t         evt
);
  bus_st_t          st;
  logic [1:0]       qtr;
  logic [3:0]       bitn;
  logic [7:0]       shf;
  logic [CNT_W-1:0] sent;
  logic             nack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      qtr     <= '0;
      bitn    <= '0;
      shf     <= '0;
      sent    <= '0;
      idx     <= '0;
      nack_q  <= 1'b0;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
      go_take <= 1'b0;
      evt     <= '0;
    end else begin
      evt     <= '0;
      go_take <= 1'b0;
      if (!en && st != S_IDLE && st != S_PARK) begin
        // park: SCL held low, SDA let go, no STOP condition
        st      <= S_PARK;
        scl_low <= 1'b1;
        sda_low <= 1'b0;
        qtr     <= '0;
      end else begin
        case (st)
          S_IDLE: if (en && start_req && mode == 2'd0) begin
            st  <= S_STA;
            qtr <= '0;
          end
          S_PARK: if (tick) begin
            scl_low <= 1'b0;
            st      <= S_IDLE;
          end
          S_STA: if (tick) begin
            qtr <= qtr + 2'd1;
            case (qtr)
              2'd0: begin sda_low <= 1'b0; scl_low <= 1'b0; end
              2'd1: sda_low <= 1'b1;
              default: begin
                scl_low     <= 1'b1;
                evt.started <= 1'b1;
                st          <= S_HOLD;
              end
            endcase
          end
          S_HOLD: begin
            if (go) begin
              go_take <= 1'b1;
              idx     <= '0;
              sent    <= '0;
              st      <= S_LDA;
            end else if (stop_req) begin
              st  <= S_STP;
              qtr <= '0;
            end
          end
          S_LDA: st <= S_LDB;
          S_LDB: begin
            shf  <= rbyte;
            bitn <= '0;
            qtr  <= '0;
            st   <= S_SEND;
          end
          S_SEND: if (tick) begin
            case (qtr)
              2'd0: begin
                sda_low <= (bitn == 4'd8) ? 1'b0 : ~shf[7];
                qtr     <= 2'd1;
              end
              2'd1: begin
                scl_low <= 1'b0;
                qtr     <= 2'd2;
              end
              2'd2: if (scl_i) begin
                if (bitn == 4'd8) nack_q <= sda_i;
                qtr <= 2'd3;
              end
              default: begin
                scl_low <= 1'b1;
                qtr     <= 2'd0;
                if (bitn != 4'd8) begin
                  shf  <= {shf[6:0], 1'b0};
                  bitn <= bitn + 4'd1;
                end else begin
                  evt.byte_sent <= 1'b1;
                  evt.nack      <= nack_q;
                  sent          <= sent + 1'b1;
                  idx           <= idx + 1'b1;
                  if (nack_q && halt) st <= S_HOLD;
                  else if (CNT_W'(sent + 1'b1) == cnt) begin
                    evt.tx_done <= 1'b1;
                    st          <= S_HOLD;
                  end else st <= S_LDA;
                end
              end
            endcase
          end
          S_STP: if (tick) begin
            qtr <= qtr + 2'd1;
            case (qtr)
              2'd0: sda_low <= 1'b1;
              2'd1: scl_low <= 1'b0;
              default: begin
                sda_low     <= 1'b0;
                evt.stopped <= 1'b1;
                st          <= S_IDLE;
              end
            endcase
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R13: inside a byte, SDA moves only while SCL is held low
  p_sda_scl_low_r13: assert property (@(posedge clk) disable iff (rst)
    (st == S_SEND && !$stable(sda_low)) |-> (scl_low && $past(scl_low)));

  // R1: the idle engine releases both lines
  p_idle_release_r1: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> (!scl_low && !sda_low));

  // R6: the parked bus keeps SCL low
  p_hold_scl_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_HOLD) |-> scl_low);
endmodule

// File: rtl/i2c_tx_engine.sv
module i2c_tx_engine
  import i2ct_pkg::*;
#(
  parameter int BUF_WORDS = 8,
  localparam int WAW = $clog2(BUF_WORDS)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_tick,
  input  logic         reg_we,
  input  logic [WAW:0] reg_addr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  input  logic         scl_i,
  input  logic         sda_i,
  output logic         scl_drive_low,
  output logic         sda_drive_low,
  output logic         irq
);
  localparam int BYTES = 4 * BUF_WORDS;
  localparam int CNT_W = $clog2(BYTES + 1);
  localparam int IW    = $clog2(BYTES);

  logic             en, start_req, stop_req, halt, go, go_take;
  logic [1:0]       mode;
  logic [CNT_W-1:0] cnt;
  logic [IW-1:0]    idx;
  logic [7:0]       rbyte;
  bus_evt_t         evt;

  i2ct_txbuf #(.WORDS(BUF_WORDS)) u_buf (
    .clk   (clk),
    .we    (reg_we && reg_addr[WAW]),
    .waddr (reg_addr[WAW-1:0]),
    .wdata (reg_wdata),
    .idx   (idx),
    .rbyte (rbyte)
  );

  i2ct_regs #(.BYTES(BYTES)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (reg_we),
    .sel_ctl   (!reg_addr[WAW]),
    .ra        (reg_addr[1:0]),
    .wdata     (reg_wdata),
    .evt       (evt),
    .go_take   (go_take),
    .en        (en),
    .mode      (mode),
    .start_req (start_req),
    .stop_req  (stop_req),
    .halt      (halt),
    .go        (go),
    .cnt       (cnt),
    .irq       (irq),
    .rdata     (reg_rdata)
  );

  i2ct_bus #(.BYTES(BYTES)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .tick      (bit_tick),
    .en        (en),
    .mode      (mode),
    .start_req (start_req),
    .stop_req  (stop_req),
    .halt      (halt),
    .go        (go),
    .cnt       (cnt),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .rbyte     (rbyte),
    .idx       (idx),
    .scl_low   (scl_drive_low),
    .sda_low   (sda_drive_low),
    .go_take   (go_take),
    .evt       (evt)
  );
endmodule

// File: tb/i2c_tx_engine_bench.sv
module i2c_tx_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS  = 4;
  localparam int NBYTES = 4 * WORDS;
  localparam logic [2:0] A_CTRL = 3'd0, A_IEN = 3'd1, A_PEND = 3'd2, A_CNT = 3'd3, A_BUF = 3'd4;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic scl_dl, sda_dl, irq;
  logic slave_low = 1'b0;
  logic scl, sda;
  logic [1:0] tdiv = '0;

  assign scl = ~scl_dl;
  assign sda = ~(sda_dl | slave_low);

  i2c_tx_engine #(.BUF_WORDS(WORDS)) u_i2c_tx_engine (
    .clk(clk), .rst(rst), .bit_tick(tick), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .scl_i(scl), .sda_i(sda),
    .scl_drive_low(scl_dl), .sda_drive_low(sda_dl), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd3);
  end

  // behavioural slave on the open-drain wires
  logic [7:0] rx_bytes [64];
  logic [7:0] sh = '0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  int bc = 0, rx_n = 0, start_cnt = 0, stop_cnt = 0, nack_at = -1;

  always @(negedge clk) begin
    if (scl && prev_scl && prev_sda && !sda) begin
      start_cnt++; bc = 0;
    end else if (scl && prev_scl && !prev_sda && sda) begin
      stop_cnt++; bc = 0;
    end else if (scl && !prev_scl) begin
      if (bc < 8) sh = {sh[6:0], sda};
      bc++;
    end else if (!scl && prev_scl) begin
      if (bc == 8) slave_low = (rx_n != nack_at);
      else if (bc == 9) begin
        slave_low = 1'b0;
        rx_bytes[rx_n % 64] = sh;
        rx_n++;
        bc = 0;
      end
    end
    prev_scl = scl;
    prev_sda = ~(sda_dl | slave_low);
  end

  int n_chk = 0, n_err = 0;
  logic [31:0] bufw [WORDS];
  logic [31:0] v;
  bit ok;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic wait_pend(input int b, output bit hit);
    logic [31:0] t;
    hit = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      rd(A_PEND, t);
      if (t[b]) begin hit = 1'b1; break; end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_buf(input logic [31:0] seed);
    for (int w = 0; w < WORDS; w++) begin
      bufw[w] = seed ^ (32'h1F2E3D4C * (w + 1));
      wr(A_BUF + 3'(w), bufw[w]);
    end
  endtask

  function automatic logic [7:0] expb(input int i);
    return bufw[i / 4][8 * (i % 4) +: 8];
  endfunction

  task automatic t_reset;
    check("R1 scl drive", 32'(scl_dl), 0);
    check("R1 sda drive", 32'(sda_dl), 0);
    check("R1 irq", 32'(irq), 0);
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_PEND, v); check("R1 pend", v, 0);
    rd(A_CNT, v);  check("R1 cnt", v, 0);
  endtask

  task automatic t_start;
    wr(A_CTRL, 32'h09);
    wait_pend(4, ok); check("R2 start flag", 32'(ok), 1);
    check("R2 start condition", 32'(start_cnt), 1);
    rd(A_CTRL, v); check("R2 start bit self-clear", v, 32'h01);
    check("R2 scl held low", 32'(scl_dl), 1);
  endtask

  task automatic t_chunk;
    int base;
    load_buf(32'hA5C3_0F96);
    wr(A_PEND, 32'h7F);
    base = rx_n;
    wr(A_CNT, 5);
    wait_pend(2, ok); check("R4 tx done", 32'(ok), 1);
    idle(4);
    check("R3 byte count", 32'(rx_n - base), 5);
    for (int i = 0; i < 5; i++) check("R3 byte value", 32'(rx_bytes[(base + i) % 64]), 32'(expb(i)));
    rd(A_PEND, v); check("R4 pend bits", v, 32'h05);
    wr(A_PEND, 32'h01);
    rd(A_PEND, v); check("R10 partial clear", v, 32'h04);
    wr(A_PEND, 32'h04);
    rd(A_PEND, v); check("R10 full clear", v, 0);
  endtask

  task automatic t_irq;
    wr(A_IEN, 32'h04);
    idle(2); check("R11 irq idle", 32'(irq), 0);
    wr(A_CNT, 1);
    wait_pend(2, ok);
    idle(2); check("R11 irq raised", 32'(irq), 1);
    wr(A_PEND, 32'h02);
    idle(2); check("R10 zero-effect clear", 32'(irq), 1);
    wr(A_PEND, 32'h7F);
    idle(2); check("R11 irq dropped", 32'(irq), 0);
    wr(A_IEN, 0);
  endtask

  task automatic t_full;
    int base, s0, p0;
    load_buf(32'h5A3C_9661);
    base = rx_n; s0 = start_cnt; p0 = stop_cnt;
    wr(A_CNT, NBYTES);
    wait_pend(2, ok); check("R8 second chunk done", 32'(ok), 1);
    idle(4);
    check("R3 full count", 32'(rx_n - base), NBYTES);
    for (int i = 0; i < NBYTES; i++) check("R3 full byte", 32'(rx_bytes[(base + i) % 64]), 32'(expb(i)));
    check("R8 no new start", 32'(start_cnt), 32'(s0));
    check("R13 no stop inside chunk", 32'(stop_cnt), 32'(p0));
    wr(A_PEND, 32'h7F);
  endtask

  task automatic t_ignore;
    int base;
    base = rx_n;
    wr(A_CNT, 0);
    wr(A_CNT, NBYTES + 1);
    idle(300);
    check("R12 no bytes", 32'(rx_n - base), 0);
    rd(A_PEND, v); check("R12 no flags", v, 0);
    rd(A_CNT, v);  check("R12 count kept", v, NBYTES);
  endtask

  task automatic t_nack_go;
    int base;
    base = rx_n; nack_at = rx_n + 1;
    wr(A_CNT, 3);
    wait_pend(2, ok); check("R5 chunk done", 32'(ok), 1);
    idle(4);
    check("R5 all sent", 32'(rx_n - base), 3);
    rd(A_PEND, v); check("R5 nack flag", v, 32'h45);
    nack_at = -1;
    wr(A_PEND, 32'h7F);
  endtask

  task automatic t_nack_halt;
    int base;
    wr(A_CTRL, 32'h41);
    base = rx_n; nack_at = rx_n + 1;
    wr(A_CNT, 4);
    wait_pend(6, ok); check("R6 nack seen", 32'(ok), 1);
    idle(400);
    check("R6 halted", 32'(rx_n - base), 2);
    rd(A_PEND, v); check("R6 no tx done", v, 32'h41);
    check("R6 scl held", 32'(scl_dl), 1);
    nack_at = -1;
    wr(A_PEND, 32'h7F);
  endtask

  task automatic t_stop;
    int p0;
    p0 = stop_cnt;
    wr(A_CTRL, 32'h51);
    wait_pend(5, ok); check("R7 stop flag", 32'(ok), 1);
    check("R7 stop condition", 32'(stop_cnt), 32'(p0 + 1));
    rd(A_CTRL, v); check("R7 stop bit self-clear", v, 32'h41);
    check("R7 scl released", 32'(scl_dl), 0);
    check("R7 sda released", 32'(sda_dl), 0);
    wr(A_PEND, 32'h7F);
  endtask

  task automatic t_mode;
    int s0;
    s0 = start_cnt;
    wr(A_CTRL, 32'h0B);
    idle(200);
    rd(A_PEND, v); check("R12 mode start ignored", v, 0);
    check("R12 no start condition", 32'(start_cnt), 32'(s0));
    wr(A_CTRL, 0);
  endtask

  task automatic t_restart;
    int s0, p0;
    wr(A_CTRL, 32'h09);
    wait_pend(4, ok);
    wr(A_PEND, 32'h7F);
    wr(A_CNT, 1);
    wait_pend(2, ok);
    s0 = start_cnt; p0 = stop_cnt;
    wr(A_CTRL, 0);
    idle(50);
    wr(A_CTRL, 32'h09);
    wait_pend(4, ok); check("R9 restart flag", 32'(ok), 1);
    check("R9 new start condition", 32'(start_cnt), 32'(s0 + 1));
    check("R9 no stop condition", 32'(stop_cnt), 32'(p0));
    rd(A_PEND, v); check("R9 no stop flag", v, 32'h15);
    wr(A_CTRL, 32'h11);
    wait_pend(5, ok);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_start();
    t_chunk();
    t_irq();
    t_full();
    t_ignore();
    t_nack_go();
    t_nack_halt();
    t_stop();
    t_mode();
    t_restart();
    finish_run();
  end
endmodule